// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port. It gives an external host read and write access to an 8-bit addressed space of byte-wide registers and memory. The host selects the port with an active-low select. It clocks bits in on a shift clock, and a level on the direction pin chooses a read or a write for the whole selection. The first byte of a selection is the address. Every byte after it is data for consecutive addresses. All serial pins are brought into the system clock domain through synchronizer stages, and both shift-clock edges are detected there.

On the inner side, each completed byte that needs the space produces one access on a request stream (valid/ready). A write finishes when its request is accepted. A read finishes when the single-cycle response strobe returns the byte. The back-pressure rules are as follows. A request, once valid, keeps its address, direction and data unchanged until the cycle in which ready is high. The response strobe has no ready and is always taken. While an access is outstanding, the wait output is high. The host must not move the shift clock past the edge that needs the result, which is the falling edge that presents read data or the first rising edge of the next byte, until wait is low again.

Top module: `ssp_serial_port`

## Requirements
- R1: With the direction pin low, the first byte of a selection is taken as the address and each later complete byte is written to the space. Bits are sampled on the rising shift-clock edge, least significant bit first.
- R2: With the direction pin high, read data leaves on the serial output least significant bit first, and the output only changes after a falling shift-clock edge. Bit 0 of the first data byte appears after the falling edge that follows the last rising edge of the address byte.
- R3: While selected with the direction pin high, the output-enable is high. With the direction pin low it is low.
- R4: While the select is high (deselected), the output-enable is low and shift-clock edges cause no access and no shifting.
- R5: The wait output rises after a byte that starts an access and stays high until that access completes. It is low when no access is outstanding.
- R6: The address advances by one after each data byte within a selection and wraps from 0xFF to 0x00.
- R7: A read of the addressed byte is issued at the end of the address byte. At the end of each read data byte, the read of the next address is issued.
- R8: Raising the select discards any partial byte: it is never written, and the next selection starts again with an address byte.
- R9: A request holds valid, direction, address and data stable until accepted. A write completes on acceptance and a read completes on the response strobe.
- R10: After reset, the output-enable, wait and request-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Shift clock from the host |
| sdi | input | 1 | Serial data from the host |
| srw | input | 1 | Direction: 1 read, 0 write |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |
| swait | output | 1 | Access in progress |
| acc_valid | output | 1 | Request valid |
| acc_ready | input | 1 | Request accepted by the space |
| acc_write | output | 1 | Request is a write |
| acc_addr | output | BYTE_W | Request address |
| acc_wdata | output | BYTE_W | Write data |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | BYTE_W | Read response byte |

## Verification
Some properties are checked on every cycle. The serial output changes only after a detected falling edge or while deselected. No access is raised in the cycle after a deselected one. A stalled request keeps its fields. Wait covers every valid request and drops only after a completion. Other behaviour can only be shown by the bench scenarios: byte order, the value of each read bit and written byte, address wrap, the prefetch address, rejection of a partial byte, and the quiet port while deselected. These are observed at the pins and in a memory model behind the request stream.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} ssp_phase_e;
  localparam int SSP_BYTE_W = 8;
  localparam int SSP_SYNC_STAGES = 2;
endpackage

// File: rtl/ssp_pin_sync.sv
module ssp_pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ssp_frame.sv
module ssp_frame
  import ssp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              srw_s,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [BYTE_W-1:0] iss_addr,
  output logic [BYTE_W-1:0] iss_data,
  input  logic              ld_valid,
  input  logic [BYTE_W-1:0] ld_data,
  output logic              sdo_q,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W-1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  logic              sclk_d;
  logic              rise, fall;
  ssp_phase_e        phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx, rx_next, addr, tx;

  assign rise    = sclk_s & ~sclk_d & ~cs_s;
  assign fall    = ~sclk_s & sclk_d & ~cs_s;
  assign rx_next = {sdi_s, rx[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      rx        <= '0;
      addr      <= '0;
      tx        <= '0;
      sdo_q     <= 1'b0;
      sdo_oe    <= 1'b0;
      iss_valid <= 1'b0;
      iss_write <= 1'b0;
      iss_addr  <= '0;
      iss_data  <= '0;
    end else begin
      sclk_d    <= sclk_s;
      iss_valid <= 1'b0;
      sdo_oe    <= ~cs_s & srw_s;
      if (cs_s) begin
        bit_cnt <= '0;
        phase   <= PH_ADDR;
        tx      <= '0;
        sdo_q   <= 1'b0;
      end else begin
        if (rise) begin
          rx      <= rx_next;
          bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CNT_ONE;
          if (bit_cnt == LAST) begin
            if (phase == PH_ADDR) begin
              phase <= PH_DATA;
              addr  <= rx_next;
              if (srw_s) begin
                iss_valid <= 1'b1;
                iss_write <= 1'b0;
                iss_addr  <= rx_next;
              end
            end else begin
              addr      <= addr + ONE;
              iss_valid <= 1'b1;
              iss_write <= ~srw_s;
              iss_addr  <= srw_s ? addr + ONE : addr;
              iss_data  <= rx_next;
            end
          end
        end
        if (fall && phase == PH_DATA && srw_s) begin
          sdo_q <= tx[0];
          tx    <= tx >> 1;
        end
        if (ld_valid) tx <= ld_data;
      end
    end
  end

  assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(fall || cs_s));

  assert_idle_no_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !iss_valid);
endmodule

// File: rtl/ssp_access.sv
module ssp_access #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_write,
  input  logic [BYTE_W-1:0] iss_addr,
  input  logic [BYTE_W-1:0] iss_data,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic              acc_write,
  output logic [BYTE_W-1:0] acc_addr,
  output logic [BYTE_W-1:0] acc_wdata,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              busy,
  output logic              ld_valid,
  output logic [BYTE_W-1:0] ld_data
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      busy      <= 1'b0;
      rd_pend   <= 1'b0;
    end else if (iss_valid && !busy) begin
      acc_valid <= 1'b1;
      acc_write <= iss_write;
      acc_addr  <= iss_addr;
      acc_wdata <= iss_data;
      busy      <= 1'b1;
      rd_pend   <= 1'b0;
    end else begin
      if (acc_valid && acc_ready) begin
        acc_valid <= 1'b0;
        if (acc_write) busy <= 1'b0;
        else rd_pend <= 1'b1;
      end
      if (rsp_valid && rd_pend) begin
        busy    <= 1'b0;
        rd_pend <= 1'b0;
      end
    end
  end

  assign ld_valid = rsp_valid & rd_pend;
  assign ld_data  = rsp_data;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_write) && $stable(acc_addr) && $stable(acc_wdata));

  assert_rsp_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rd_pend);

  assert_wait_covers_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> busy);

  assert_wait_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rsp_valid) || $past(acc_valid && acc_ready && acc_write));
endmodule

// File: rtl/ssp_serial_port.sv
module ssp_serial_port
  import ssp_pkg::*;
#(
  parameter int BYTE_W = SSP_BYTE_W,
  parameter int SYNC_STAGES = SSP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              srw,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              swait,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic              acc_write,
  output logic [BYTE_W-1:0] acc_addr,
  output logic [BYTE_W-1:0] acc_wdata,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data
);
  localparam int NPIN = 4;

  logic [NPIN-1:0]   pins_s;
  logic              iss_valid, iss_write, ld_valid;
  logic [BYTE_W-1:0] iss_addr, iss_data, ld_data;

  ssp_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({srw, sdi, sclk, cs_n}),
    .dout(pins_s)
  );

  ssp_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s[0]), .sclk_s(pins_s[1]), .sdi_s(pins_s[2]), .srw_s(pins_s[3]),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr), .iss_data(iss_data),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .sdo_q(sdo), .sdo_oe(sdo_oe)
  );

  ssp_access #(.BYTE_W(BYTE_W)) u_access (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr), .iss_data(iss_data),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(swait), .ld_valid(ld_valid), .ld_data(ld_data)
  );
endmodule

// File: tb/test_ssp_serial_port.sv
module test_ssp_serial_port;
  localparam int HALF = 8;
  localparam int NV = 8;
  // {write, addr, byte0, byte1}; read rows hold the expected contents
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h10, 8'hA5, 8'h3C},
    {1'b1, 8'hFF, 8'h81, 8'h7E},
    {1'b0, 8'h10, 8'hA5, 8'h3C},
    {1'b0, 8'hFF, 8'h81, 8'h7E},
    {1'b1, 8'h40, 8'h00, 8'hFF},
    {1'b0, 8'h40, 8'h00, 8'hFF},
    {1'b1, 8'h80, 8'h5A, 8'hC3},
    {1'b0, 8'h81, 8'hC3, 8'hD7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, srw = 1'b0;
  logic sdo, sdo_oe, swait, acc_valid, acc_write, acc_ready, rsp_valid;
  logic [7:0] acc_addr, acc_wdata, rsp_data;

  logic [7:0] mem [256];
  int nreq, hold_err, wcnt, rcnt;
  logic [7:0] raddr, last_raddr;
  logic prev_stall, pw;
  logic [7:0] pa, pd;
  int tests = 0, fails = 0;
  logic wait_seen, oe_seen;

  always #2.5 clk = ~clk;

  ssp_serial_port i_ssp_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .srw(srw),
    .sdo(sdo), .sdo_oe(sdo_oe), .swait(swait),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // memory model behind the request stream
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h55;
      acc_ready <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0;
      wcnt <= 0; rcnt <= 0; nreq <= 0; hold_err <= 0;
      raddr <= '0; last_raddr <= '0;
      prev_stall <= 1'b0; pw <= 1'b0; pa <= '0; pd <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (prev_stall && (!acc_valid || acc_write != pw || acc_addr != pa || acc_wdata != pd))
        hold_err <= hold_err + 1;
      prev_stall <= acc_valid && !acc_ready;
      pw <= acc_write; pa <= acc_addr; pd <= acc_wdata;
      if (acc_valid && acc_ready) begin
        acc_ready <= 1'b0; wcnt <= 0; nreq <= nreq + 1;
        if (acc_write) mem[acc_addr] <= acc_wdata;
        else begin rcnt <= 5; raddr <= acc_addr; last_raddr <= acc_addr; end
      end else if (acc_valid) begin
        if (wcnt == 2) acc_ready <= 1'b1;
        else wcnt <= wcnt + 1;
      end
      if (rcnt != 0) begin
        rcnt <= rcnt - 1;
        if (rcnt == 1) begin rsp_valid <= 1'b1; rsp_data <= mem[raddr]; end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sdi = b[i];
      repeat (HALF) @(negedge clk);
      got[i] = sdo; oe_seen = sdo_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == 7) begin
        wait_seen = swait;
        while (swait) @(negedge clk);
      end
      sclk = 1'b0;
    end
  endtask

  task automatic frame_start(input logic dir);
    @(negedge clk); srw = dir; sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    while (swait) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] r, r0, r1, a, d0, d1;
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 sdo_oe", 32'(sdo_oe), 0);
    check("R10 swait", 32'(swait), 0);
    check("R10 acc_valid", 32'(acc_valid), 0);

    for (int v = 0; v < NV; v++) begin
      a = VEC[v][23:16]; d0 = VEC[v][15:8]; d1 = VEC[v][7:0];
      if (VEC[v][24]) begin
        frame_start(1'b0);
        xfer(a, 8, r); xfer(d0, 8, r); xfer(d1, 8, r);
        check("R3 no drive when writing", 32'(oe_seen), 0);
        frame_end();
        check("R1 first data byte written", 32'(mem[a]), 32'(d0));
        check("R6 next address written", 32'(mem[8'(a + 8'd1)]), 32'(d1));
      end else begin
        frame_start(1'b1);
        xfer(a, 8, r);
        check("R5 wait high during fetch", 32'(wait_seen), 1);
        check("R7 prefetch address", 32'(last_raddr), 32'(a));
        xfer(8'h00, 8, r0);
        check("R3 drive when reading", 32'(oe_seen), 1);
        check("R7 next fetch address", 32'(last_raddr), 32'(8'(a + 8'd1)));
        xfer(8'h00, 8, r1);
        frame_end();
        check("R2 first read byte", 32'(r0), 32'(d0));
        check("R6 second read byte", 32'(r1), 32'(d1));
        check("R5 wait low when idle", 32'(swait), 0);
      end
    end

    // R4: deselected, clock toggles must do nothing
    n0 = nreq;
    @(negedge clk); srw = 1'b1; cs_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sdi = i[0]; sclk = ~sclk;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0;
    check("R4 no request while deselected", 32'(nreq), 32'(n0));
    check("R4 no drive while deselected", 32'(sdo_oe), 0);
    check("R4 wait stays low", 32'(swait), 0);

    // R8: partial byte abort
    n0 = nreq;
    frame_start(1'b0);
    xfer(8'h20, 8, r); xfer(8'hFF, 5, r);
    frame_end();
    check("R8 partial byte not written", 32'(mem[8'h20]), 32'h75);
    check("R8 no request for partial byte", 32'(nreq), 32'(n0));
    frame_start(1'b0);
    xfer(8'h20, 8, r); xfer(8'h99, 8, r);
    frame_end();
    check("R8 new frame realigned", 32'(mem[8'h20]), 32'h99);
    check("R8 neighbour untouched", 32'(mem[8'h21]), 32'h74);

    check("R9 request held while stalled", 32'(hold_err), 0);
    finish_run();
  end
endmodule